// File: doc/BRIEF.md
# Shared Work-RAM Arbiter with Processor Wait States

This block places one single-port word RAM between two masters. A host bus and a local 16-bit processor can both reach it. The host side is a streaming port with priority. It has a combinational grant and a completion strobe one clock later. The processor side is a request/ready bus. Whenever the RAM is taken by the host, the block holds the processor's ready low, so the processor bus cycle stretches by one wait state for every clock it loses.

The processor sees a byte-addressed window. The lowest part of that window is a small bank of word registers, and everything above it maps onto the RAM. The RAM word index comes from the low address bits, so the RAM repeats (aliases) through the rest of the window. An upper-byte enable and address bit 0 together select which byte lanes an access touches. The RAM accepts byte and word accesses. The register bank accepts word accesses only.

A streak counter caps the run of host wins against a waiting processor. This keeps the processor's worst-case latency bounded even under continuous host traffic.

Top module: `shram_arbiter`

## Requirements
- R1: When `h_req` and a processor RAM request are pending in the same cycle (and the streak cap is not reached), `h_gnt` is 1 in that cycle. The processor's `p_ready` stays 0 in the following cycle, and the host write is visible to the processor access that follows it.
- R2: A processor RAM access with no host traffic raises `p_ready` for one cycle, exactly one clock after its request is first sampled (zero wait states). Each clock lost to the host adds one wait state.
- R3: A processor access to the register window completes with zero wait states, even while the host is requesting every cycle.
- R4: Lane decode from {`p_hi_en`, `p_addr[0]`}:
  - 1,0 selects the full word.
  - 0,0 selects the low lane, bits [7:0].
  - 1,1 selects the odd byte on the high lane, bits [15:8].
  - 0,1 selects no lane: a write changes nothing and a read returns zero.
- R5: A processor byte write to RAM changes only the selected lane of the addressed word.
- R6: A processor byte read returns the selected lane in its own bit position, with the other lane zero. An odd byte appears on `p_rdata[15:8]`.
- R7: Processor byte addresses below 2^(REG_AW+1) (16 by default) select register word `p_addr[REG_AW:1]`. All other addresses select RAM word `p_addr[RAM_AW:1]`, so addresses that differ only above bit RAM_AW reach the same word.
- R8: The register window is word-only. A byte write to it is ignored, and a byte read from it returns zero.
- R9: With the host requesting every cycle, a waiting processor RAM access is granted after at most MAX_STREAK (8) consecutive host grants. `h_gnt` is 0 in that one cycle and `p_ready` follows it.
- R10: Each granted access holds the RAM for exactly one clock. `h_done` follows `h_gnt` by one clock, and for a host read `h_rdata` then carries the addressed word.
- R11: After reset, `p_ready` and `h_done` are 0 and all registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req | input | 1 | Host access request (one access per granted cycle) |
| h_we | input | 1 | Host write when 1 |
| h_addr | input | RAM_AW | Host RAM word index |
| h_be | input | 2 | Host byte-lane enables, bit 1 = [15:8] |
| h_wdata | input | 16 | Host write data |
| h_gnt | output | 1 | Host access performed at the coming clock edge |
| h_done | output | 1 | Host access completed; read data valid |
| h_rdata | output | 16 | Host read data |
| p_req | input | 1 | Processor request, held until `p_ready` |
| p_we | input | 1 | Processor write when 1 |
| p_addr | input | ADDR_W | Processor byte address |
| p_hi_en | input | 1 | Processor upper byte enable (active high) |
| p_wdata | input | 16 | Processor write data, lane positioned |
| p_ready | output | 1 | Processor access complete (one-cycle pulse) |
| p_rdata | output | 16 | Processor read data, lane masked |

## Verification
The hardest case to reach from the ports is the streak cap. Hitting it needs the host to win eight consecutive clocks while a processor RAM request is waiting. The bench sets up this case directly: it holds `h_req` high with reads, and the processor request is raised on the same edge. The bench then checks the one cycle where `h_gnt` drops and the exact wait-state count. Random processor accesses, with random lanes, regions and aliased addresses, are interleaved with host writes and reads and compared against a bench-side memory model.

// File: rtl/shram_pkg.sv
package shram_pkg;

   typedef enum logic [1:0] {
      LANE_NONE = 2'b00,
      LANE_LO   = 2'b01,
      LANE_HI   = 2'b10,
      LANE_BOTH = 2'b11
   } lane_e;

   // upper-enable and address bit 0 to lane set
   function automatic lane_e lanes_of(input logic hi_en, input logic a0);
      case ({hi_en, a0})
         2'b10:   return LANE_BOTH;
         2'b00:   return LANE_LO;
         2'b11:   return LANE_HI;
         default: return LANE_NONE;
      endcase
   endfunction

   function automatic logic [15:0] lane_mask(input lane_e l);
      logic [1:0] b;
      b = l;
      return {{8{b[1]}}, {8{b[0]}}};
   endfunction

endpackage

// File: rtl/shram_lane_dec.sv
module shram_lane_dec
   import shram_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int RAM_AW = 10,
   parameter int REG_AW = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              hi_en,
   output lane_e             lanes,
   output logic              is_reg,
   output logic [RAM_AW-1:0] ram_idx,
   output logic [REG_AW-1:0] reg_idx
);
   localparam int WIN_LSB = REG_AW + 1;

   always_comb begin
      lanes   = lanes_of(hi_en, addr[0]);
      is_reg  = (addr[ADDR_W-1:WIN_LSB] == '0);
      ram_idx = addr[RAM_AW:1];
      reg_idx = addr[REG_AW:1];
   end
endmodule

// File: rtl/shram_arb.sv
module shram_arb #(
   parameter int MAX_STREAK = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic h_req,
   input  logic p_req,
   output logic h_gnt,
   output logic p_gnt
);
   localparam int SW = $clog2(MAX_STREAK + 1);

   logic [SW-1:0] streak_q;
   logic          capped;

   always_comb begin
      capped = p_req && (streak_q == SW'(MAX_STREAK));
      h_gnt  = h_req && !capped;
      p_gnt  = p_req && !h_gnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             streak_q <= '0;
      else if (p_req && h_gnt) streak_q <= streak_q + 1'b1;
      else                    streak_q <= '0;
   end

   // R9
   streak_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      streak_q <= SW'(MAX_STREAK));

   // R9
   waiting_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_req && streak_q == SW'(MAX_STREAK)) |-> (p_gnt && !h_gnt));
endmodule

// File: rtl/shram_store.sv
module shram_store #(
   parameter int AW     = 10,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W/8-1:0] be,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int LANES = DATA_W / 8;
   localparam int DEPTH = 2 ** AW;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] bank [DEPTH];
      logic [7:0] rd_q;

      always_ff @(posedge clk) begin
         if (en) begin
            if (we && be[g]) bank[addr] <= wdata[g*8 +: 8];
            rd_q <= bank[addr];
         end
      end

      assign rdata[g*8 +: 8] = rd_q;
   end
endmodule

// File: rtl/shram_regs.sv
module shram_regs #(
   parameter int REG_AW = 3,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              we,
   input  logic              full,
   input  logic [REG_AW-1:0] idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata_q
);
   localparam int NREG = 2 ** REG_AW;

   logic [DATA_W-1:0] file_q [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) file_q[i] <= '0;
         rdata_q <= '0;
      end else if (acc) begin
         if (we && full) file_q[idx] <= wdata;
         rdata_q <= full ? file_q[idx] : '0;
      end
   end

   // R8
   byte_reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !full) |=> (rdata_q == '0));

   // R8
   byte_reg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !full) |=> (file_q[$past(idx)] == $past(file_q[idx])));
endmodule

// File: rtl/shram_arbiter.sv
module shram_arbiter
   import shram_pkg::*;
#(
   parameter int ADDR_W     = 18,
   parameter int RAM_AW     = 10,
   parameter int REG_AW     = 3,
   parameter int DATA_W     = 16,
   parameter int MAX_STREAK = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_req,
   input  logic              h_we,
   input  logic [RAM_AW-1:0] h_addr,
   input  logic [1:0]        h_be,
   input  logic [DATA_W-1:0] h_wdata,
   output logic              h_gnt,
   output logic              h_done,
   output logic [DATA_W-1:0] h_rdata,
   input  logic              p_req,
   input  logic              p_we,
   input  logic [ADDR_W-1:0] p_addr,
   input  logic              p_hi_en,
   input  logic [DATA_W-1:0] p_wdata,
   output logic              p_ready,
   output logic [DATA_W-1:0] p_rdata
);
   if (DATA_W != 16) begin : g_bad_width
      $error("shram_arbiter: lane decode needs DATA_W == 16");
   end
   if (RAM_AW + 1 > ADDR_W || REG_AW + 1 >= ADDR_W) begin : g_bad_map
      $error("shram_arbiter: RAM or register window exceeds the address space");
   end
   if (MAX_STREAK < 1) begin : g_bad_streak
      $error("shram_arbiter: MAX_STREAK must be at least 1");
   end

   lane_e             p_lanes;
   logic              p_is_reg;
   logic [RAM_AW-1:0] p_ram_idx;
   logic [REG_AW-1:0] p_reg_idx;
   logic              p_pend, p_ram_req, p_gnt;
   logic              ram_en, ram_we;
   logic [RAM_AW-1:0] ram_addr;
   logic [1:0]        ram_be;
   logic [DATA_W-1:0] ram_wdata, ram_rdata, reg_rdata;
   logic              p_ready_q, h_done_q, src_reg_q;
   logic [DATA_W-1:0] mask_q;

   shram_lane_dec #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .REG_AW(REG_AW)) i_dec (
      .addr(p_addr), .hi_en(p_hi_en), .lanes(p_lanes),
      .is_reg(p_is_reg), .ram_idx(p_ram_idx), .reg_idx(p_reg_idx)
   );

   assign p_pend    = p_req && !p_ready_q;
   assign p_ram_req = p_pend && !p_is_reg;

   shram_arb #(.MAX_STREAK(MAX_STREAK)) i_arb (
      .clk(clk), .rst_n(rst_n), .h_req(h_req), .p_req(p_ram_req),
      .h_gnt(h_gnt), .p_gnt(p_gnt)
   );

   always_comb begin
      ram_en    = h_gnt || p_gnt;
      ram_we    = h_gnt ? h_we    : p_we;
      ram_addr  = h_gnt ? h_addr  : p_ram_idx;
      ram_be    = h_gnt ? h_be    : p_lanes;
      ram_wdata = h_gnt ? h_wdata : p_wdata;
   end

   shram_store #(.AW(RAM_AW), .DATA_W(DATA_W)) i_store (
      .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
      .be(ram_be), .wdata(ram_wdata), .rdata(ram_rdata)
   );

   shram_regs #(.REG_AW(REG_AW), .DATA_W(DATA_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .acc(p_pend && p_is_reg), .we(p_we),
      .full(p_lanes == LANE_BOTH), .idx(p_reg_idx), .wdata(p_wdata),
      .rdata_q(reg_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_ready_q <= 1'b0;
         h_done_q  <= 1'b0;
         src_reg_q <= 1'b0;
         mask_q    <= '0;
      end else begin
         p_ready_q <= p_gnt || (p_pend && p_is_reg);
         h_done_q  <= h_gnt;
         if (p_pend) begin
            src_reg_q <= p_is_reg;
            mask_q    <= lane_mask(p_lanes);
         end
      end
   end

   assign p_ready = p_ready_q;
   assign h_done  = h_done_q;
   assign h_rdata = ram_rdata;
   assign p_rdata = (src_reg_q ? reg_rdata : ram_rdata) & mask_q;

   // R3
   reg_zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_pend && p_is_reg) |=> p_ready);

   // R1
   host_stalls_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_gnt && p_ram_req) |=> !p_ready);

   // R2
   ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      p_ready |-> $past(p_req));

   // R10
   host_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      h_gnt |=> h_done);
endmodule

// File: tb/test_shram_arbiter.sv
`timescale 1ns/1ps
module test_shram_arbiter;
   localparam int ADDR_W = 18;
   localparam int RAM_AW = 10;
   localparam int NWORD  = 2 ** RAM_AW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_req = 0, h_we = 0;
   logic [RAM_AW-1:0] h_addr = '0;
   logic [1:0]  h_be = 2'b11;
   logic [15:0] h_wdata = '0;
   logic        h_gnt, h_done;
   logic [15:0] h_rdata;
   logic        p_req = 0, p_we = 0, p_hi_en = 0;
   logic [ADDR_W-1:0] p_addr = '0;
   logic [15:0] p_wdata = '0;
   logic        p_ready;
   logic [15:0] p_rdata;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 0;

   logic [15:0] ram_m [NWORD];
   logic [15:0] reg_m [8];

   always #4 clk = ~clk;

   shram_arbiter i_shram_arbiter (
      .clk(clk), .rst_n(rst_n),
      .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_be(h_be), .h_wdata(h_wdata),
      .h_gnt(h_gnt), .h_done(h_done), .h_rdata(h_rdata),
      .p_req(p_req), .p_we(p_we), .p_addr(p_addr), .p_hi_en(p_hi_en), .p_wdata(p_wdata),
      .p_ready(p_ready), .p_rdata(p_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] lanes_m(input logic hi, input logic a0);
      case ({hi, a0})
         2'b10:   return 2'b11;
         2'b00:   return 2'b01;
         2'b11:   return 2'b10;
         default: return 2'b00;
      endcase
   endfunction

   function automatic bit is_reg_m(input logic [ADDR_W-1:0] a);
      return a < 16;
   endfunction

   function automatic logic [15:0] exp_read(input logic [ADDR_W-1:0] a, input logic hi);
      logic [1:0]  l;
      logic [15:0] w;
      l = lanes_m(hi, a[0]);
      if (is_reg_m(a)) return (l == 2'b11) ? reg_m[a[3:1]] : 16'h0;
      w = ram_m[a[RAM_AW:1]];
      return w & {{8{l[1]}}, {8{l[0]}}};
   endfunction

   function automatic void model_write(input logic [ADDR_W-1:0] a, input logic hi, input logic [15:0] d);
      logic [1:0] l;
      l = lanes_m(hi, a[0]);
      if (is_reg_m(a)) begin
         if (l == 2'b11) reg_m[a[3:1]] = d;
      end else begin
         if (l[0]) ram_m[a[RAM_AW:1]][7:0]  = d[7:0];
         if (l[1]) ram_m[a[RAM_AW:1]][15:8] = d[15:8];
      end
   endfunction

   task automatic proc_access(input logic we, input logic [ADDR_W-1:0] a, input logic hi,
                              input logic [15:0] wd, output logic [15:0] rd, output int waits);
      @(negedge clk);
      p_req = 1; p_we = we; p_addr = a; p_hi_en = hi; p_wdata = wd;
      waits = 0;
      forever begin
         @(negedge clk);
         if (p_ready || waits > 40) break;
         waits++;
      end
      rd = p_rdata;
      p_req = 0; p_we = 0;
      if (we) model_write(a, hi, wd);
   endtask

   task automatic host_access(input logic we, input logic [RAM_AW-1:0] a,
                              input logic [1:0] be, input logic [15:0] d, output logic [15:0] rd);
      @(negedge clk);
      h_req = 1; h_we = we; h_addr = a; h_be = be; h_wdata = d;
      #1;
      while (!h_gnt) begin @(negedge clk); #1; end
      @(negedge clk);
      rd = h_rdata;
      h_req = 0; h_we = 0;
      if (we) begin
         if (be[0]) ram_m[a][7:0]  = d[7:0];
         if (be[1]) ram_m[a][15:8] = d[15:8];
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] rd;
      int          w;
      int          lowcyc;
      bit          got;
      void'($urandom(32'h5EED_2024));
      for (int i = 0; i < 8; i++) reg_m[i] = '0;

      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 p_ready in reset", p_ready, 0);
      chk("R11 h_done in reset", h_done, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R11 p_ready after reset", p_ready, 0);
      proc_access(0, 18'd6, 1, 16'h0, rd, w);
      chk("R11 register reads zero", rd, 16'h0);

      // preload RAM through the host port
      for (int i = 0; i < NWORD; i++)
         host_access(1, RAM_AW'(i), 2'b11, 16'(i * 40503) ^ 16'h5A5A, rd);

      // R10 host read returns the word
      host_access(0, 10'd77, 2'b11, 16'h0, rd);
      chk("R10 host read data", rd, ram_m[77]);

      // R2 uncontended RAM word read, zero waits
      proc_access(0, 18'd80, 1, 16'h0, rd, w);
      chk("R2 zero wait states", w, 0);
      chk("R2 word read data", rd, ram_m[40]);

      // R5 R6 odd byte write, then word and byte reads
      proc_access(1, 18'd81, 1, 16'hC300, rd, w);
      proc_access(0, 18'd80, 1, 16'h0, rd, w);
      chk("R5 odd byte write keeps low lane", rd, ram_m[40]);
      chk("R5 odd byte landed", rd[15:8], 8'hC3);
      proc_access(0, 18'd81, 1, 16'h0, rd, w);
      chk("R6 odd byte read on high lane", rd, {8'hC3, 8'h00});
      proc_access(1, 18'd80, 0, 16'h0096, rd, w);
      proc_access(0, 18'd80, 0, 16'h0, rd, w);
      chk("R6 even byte read on low lane", rd, {8'h00, 8'h96});

      // R4 reserved lane combination: no write, zero read
      proc_access(1, 18'd81, 0, 16'hFFFF, rd, w);
      proc_access(0, 18'd80, 1, 16'h0, rd, w);
      chk("R4 no-lane write ignored", rd, 16'hC396);
      proc_access(0, 18'd81, 0, 16'h0, rd, w);
      chk("R4 no-lane read zero", rd, 16'h0);

      // R7 aliasing above bit RAM_AW
      proc_access(0, 18'd80 + 18'd2048, 1, 16'h0, rd, w);
      chk("R7 alias reaches same word", rd, 16'hC396);

      // R8 register window word only
      proc_access(1, 18'd4, 1, 16'hBEEF, rd, w);
      proc_access(1, 18'd4, 0, 16'h1111, rd, w);
      proc_access(1, 18'd5, 1, 16'h2222, rd, w);
      proc_access(0, 18'd4, 1, 16'h0, rd, w);
      chk("R8 byte writes to register ignored", rd, 16'hBEEF);
      proc_access(0, 18'd5, 1, 16'h0, rd, w);
      chk("R8 byte read of register zero", rd, 16'h0);

      // R1 simultaneous request: host first, its write seen by processor
      @(negedge clk);
      h_req = 1; h_we = 1; h_addr = 10'd40; h_be = 2'b11; h_wdata = 16'h1234;
      p_req = 1; p_we = 0; p_addr = 18'd80; p_hi_en = 1;
      #1 chk("R1 host granted on tie", h_gnt, 1);
      @(negedge clk);
      chk("R1 host done", h_done, 1);
      chk("R1 processor held off", p_ready, 0);
      h_req = 0; h_we = 0; ram_m[40] = 16'h1234;
      @(negedge clk);
      chk("R2 one wait state then ready", p_ready, 1);
      chk("R1 processor sees host write", p_rdata, 16'h1234);
      p_req = 0;

      // R9 streak cap under continuous host reads
      @(negedge clk);
      h_req = 1; h_we = 0; h_addr = 10'd7;
      p_req = 1; p_we = 0; p_addr = 18'd80; p_hi_en = 1;
      lowcyc = -1; got = 0; w = -1;
      for (int k = 0; k < 14 && !got; k++) begin
         #1 if (!h_gnt && lowcyc < 0) lowcyc = k;
         @(negedge clk);
         if (p_ready) begin got = 1; w = k; rd = p_rdata; end
      end
      p_req = 0;
      chk("R9 processor waits eight cycles", w, 8);
      chk("R9 host loses exactly cycle eight", lowcyc, 8);
      chk("R9 data after starvation", rd, 16'h1234);
      #1 chk("R9 host regains grant", h_gnt, 1);
      @(negedge clk);

      // R3 register access during continuous host traffic
      p_req = 1; p_we = 0; p_addr = 18'd4; p_hi_en = 1;
      @(negedge clk);
      chk("R3 register zero wait under host load", p_ready, 1);
      chk("R3 register data", p_rdata, 16'hBEEF);
      p_req = 0;
      @(negedge clk);
      h_req = 0;

      // random mix
      for (int n = 0; n < 500; n++) begin
         logic [31:0] r;
         logic [ADDR_W-1:0] a;
         logic [15:0] d, e;
         r = $urandom;
         d = 16'($urandom);
         if (r[2:0] == 3'd0) begin
            host_access(1, RAM_AW'($urandom), 2'($urandom | 1), d, rd);
         end else if (r[2:0] == 3'd1) begin
            a = ADDR_W'($urandom);
            host_access(0, a[RAM_AW-1:0], 2'b11, 16'h0, rd);
            chk("R10 random host read", rd, ram_m[a[RAM_AW-1:0]]);
         end else begin
            if (r[4:3] == 2'd0) a = {14'd0, 3'($urandom), r[5]};
            else begin
               a = ADDR_W'($urandom);
               if (a[ADDR_W-1:4] == '0) a[4] = 1'b1;
               a[0] = r[5];
            end
            if (r[6]) begin
               proc_access(1, a, r[7], d, rd, w);
            end else begin
               e = exp_read(a, r[7]);
               proc_access(0, a, r[7], 16'h0, rd, w);
               chk(is_reg_m(a) ? "R8 random register read" : "R6 random RAM read", rd, e);
            end
            chk("R2 random zero waits", w, 0);
         end
      end

      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule